// File: doc/BRIEF.md
# Prioritized Trap Arbitration Controller

This controller gathers non-maskable fault requests from up to eight sources and decides which one the processor services. Each source owns one slot at a fixed priority level. The lower half of the slots forms a soft class. A soft request passes through an extra sampling stage before the core sees it, so the core may keep executing in the meantime. The upper half forms a hard class. A hard request is seen at once, and it holds the core stalled until the trap has been acknowledged and retired.

The core sees one vector, the level number of the winning trap, together with a valid strobe. It answers with an acknowledge, and later with an end-of-service pulse. The controller keeps one pending bit and one in-service bit per slot. When a more urgent trap arrives, it is presented over the one in service. The interrupted trap stays suspended and resumes after the urgent one retires. A hard request can arrive while a more urgent trap is still outstanding. That situation cannot be untangled, so the controller then asks the system for a reset and latches a sticky conflict flag. This flag survives the reset.

Each source also has a status flag that software clears by a write. For the arithmetic and oscillator slots, the clear is refused while the fault condition is still present.

Top module: `trap_arb_ctrl`

## Requirements
- R1: On `rst` or `por`: no trap is pending or in service, `vec_valid`, `stall`, `reset_req` and `trap_flags` are all 0. Only `por` also clears `conflict_sticky`.
- R2: Slot i (bit i of `trap_req`) has priority level 8+i, and `vec_level` carries that level. Slots 0..3 (levels 8..11) are soft, and slots 4..7 (levels 12..15) are hard. Arithmetic is slot 3 (level 11), address fault is slot 4 (12), stack fault is slot 5 (13) and oscillator failure is slot 6 (14).
- R3: A rising `trap_req` bit on a hard slot that is sampled at one clock edge is presented from that edge on. `stall` is 1 while any hard slot is pending or in service.
- R4: A soft slot's rising request is presented one edge later than a hard one (two edges after sampling). Soft traps never raise `stall`.
- R5: When several traps are pending, the highest level wins. The others stay pending and are presented in descending order as each one retires.
- R6: `vec_valid` stays 1 until `core_ack`. The acknowledge moves the presented trap into service, and `vec_valid` falls unless a higher trap is pending.
- R7: A pending trap above the highest in-service trap is presented at once (preemption). A pending trap below it is not presented.
- R8: `core_done` retires only the highest in-service trap. Suspended traps resume without a new acknowledge, so a lower pending trap stays hidden until they retire too.
- R9: A rising hard request while any higher slot is pending or in service sets `reset_req` at that edge and holds it until `rst`. It also sets `conflict_sticky`.
- R10: `conflict_sticky` survives `rst` and is cleared by `conflict_clr` or `por`. Simultaneous hard arrivals, higher arrivals and soft arrivals cause no conflict.
- R11: A rising request sets its `trap_flags` bit. `flag_clr` clears it, but on bits 3 and 6 the clear is ignored while that request is still high.
- R12: `core_done` with nothing in service changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; keeps the sticky conflict flag |
| por | input | 1 | Synchronous power-on reset; clears everything |
| trap_req | input | 8 | Fault conditions, one per slot; the rising edge is the event |
| flag_clr | input | 8 | Software write-to-clear of status flags |
| core_ack | input | 1 | Core accepts the presented vector |
| core_done | input | 1 | Core finished servicing the current trap |
| conflict_clr | input | 1 | Software write-to-clear of the sticky conflict flag |
| vec_valid | output | 1 | A trap vector is being presented |
| vec_level | output | 4 | Priority level of the presented trap |
| stall | output | 1 | Halt instruction execution (hard trap outstanding) |
| reset_req | output | 1 | Device reset request after a hard conflict |
| conflict_sticky | output | 1 | Latched hard-conflict status |
| trap_flags | output | 8 | Per-slot status flags |

## Verification
The hardest state to reach from the ports is a suspended trap that is still in service beneath a preempting one. It cannot be seen directly, because no output shows the in-service set. The stimulus acknowledges a soft trap at level 9 and lets a hard trap at level 12 preempt it. It then injects a level-8 soft trap while level 12 is in service. When level 12 retires, the vector must stay invalid, since level 9 still blocks level 8. Only the second retire may reveal level 8. The conflict reset is reached by leaving a level-14 trap unacknowledged and raising level 12 under it.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;

    localparam int NUM_TRAPS  = 8;
    localparam int SOFT_TRAPS = 4;
    localparam int BASE_LEVEL = 8;
    localparam int IDX_W      = $clog2(NUM_TRAPS);
    localparam int LVL_W      = 4;
    localparam int ARITH_IDX  = 3;
    localparam int OSC_IDX    = 6;

    typedef logic [NUM_TRAPS-1:0] trap_vec_t;

    localparam trap_vec_t HARD_MASK = ~trap_vec_t'((1 << SOFT_TRAPS) - 1);
    localparam trap_vec_t HOLD_MASK = trap_vec_t'((1 << ARITH_IDX) | (1 << OSC_IDX));

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Highest set bit of a slot vector.
    function automatic pick_t pick_highest(input trap_vec_t v);
        pick_t r;
        r.valid = 1'b0;
        r.idx   = '0;
        for (int i = 0; i < NUM_TRAPS; i++) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.idx   = IDX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [LVL_W-1:0] idx_to_level(input logic [IDX_W-1:0] idx);
        return LVL_W'(BASE_LEVEL) + LVL_W'(idx);
    endfunction

    // Slots strictly more urgent than idx.
    function automatic trap_vec_t above_mask(input logic [IDX_W-1:0] idx);
        trap_vec_t m;
        for (int i = 0; i < NUM_TRAPS; i++) begin
            m[i] = (i > int'(idx));
        end
        return m;
    endfunction

endpackage

// File: rtl/trap_capture.sv
module trap_capture
    import trap_arb_pkg::*;
#(
    parameter int SOFT_DELAY = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      por,
    input  trap_vec_t trap_req,
    input  trap_vec_t flag_clr,
    output trap_vec_t rise_o,
    output trap_vec_t pend_set_o,
    output trap_vec_t flags_o
);

    logic      clr_all;
    trap_vec_t prev_q;
    trap_vec_t rise;
    trap_vec_t flags_q;
    trap_vec_t clr_ok;
    logic [SOFT_TRAPS-1:0] soft_set;

    assign clr_all = rst | por;

    always_ff @(posedge clk) begin
        if (clr_all) prev_q <= '0;
        else         prev_q <= trap_req;
    end

    assign rise = trap_req & ~prev_q;

    generate
        if (SOFT_DELAY <= 1) begin : g_direct
            assign soft_set = rise[SOFT_TRAPS-1:0];
        end else begin : g_pipe
            logic [SOFT_TRAPS-1:0] stage_q [SOFT_DELAY-1];
            always_ff @(posedge clk) begin
                if (clr_all) begin
                    for (int k = 0; k < SOFT_DELAY - 1; k++) stage_q[k] <= '0;
                end else begin
                    stage_q[0] <= rise[SOFT_TRAPS-1:0];
                    for (int k = 1; k < SOFT_DELAY - 1; k++) stage_q[k] <= stage_q[k-1];
                end
            end
            assign soft_set = stage_q[SOFT_DELAY-2];
        end
    endgenerate

    assign pend_set_o = {rise[NUM_TRAPS-1:SOFT_TRAPS], soft_set};
    assign rise_o     = rise;

    // Clears on held-condition slots are refused while the source is active.
    assign clr_ok = flag_clr & ~(HOLD_MASK & trap_req);

    always_ff @(posedge clk) begin
        if (clr_all) flags_q <= '0;
        else         flags_q <= (flags_q & ~clr_ok) | rise;
    end

    assign flags_o = flags_q;

    p_arith_hold_r11: assert property (@(posedge clk) disable iff (clr_all)
        flags_q[ARITH_IDX] && trap_req[ARITH_IDX] |=> flags_q[ARITH_IDX]);

    p_osc_hold_r11: assert property (@(posedge clk) disable iff (clr_all)
        flags_q[OSC_IDX] && trap_req[OSC_IDX] |=> flags_q[OSC_IDX]);

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_arb_pkg::*;
(
    input  trap_vec_t pend,
    input  trap_vec_t svc,
    output pick_t     win_o,
    output pick_t     top_o
);

    pick_t pend_hi;
    pick_t svc_hi;

    always_comb begin
        pend_hi = pick_highest(pend);
        svc_hi  = pick_highest(svc);
        win_o   = pend_hi;
        // A pending trap is offered only if it outranks everything in service.
        if (svc_hi.valid && (pend_hi.idx <= svc_hi.idx)) win_o.valid = 1'b0;
        top_o   = svc_hi;
    end

endmodule

// File: rtl/trap_tracker.sv
module trap_tracker
    import trap_arb_pkg::*;
(
    input  logic             clk,
    input  logic             clr_all,
    input  trap_vec_t        pend_set,
    input  logic             core_ack,
    input  logic             core_done,
    output logic             vec_valid,
    output logic [LVL_W-1:0] vec_level,
    output logic             stall,
    output trap_vec_t        outstanding_o
);

    trap_vec_t pend_q, svc_q;
    trap_vec_t pend_n, svc_n;
    pick_t     win, top;

    trap_arbiter u_arb (
        .pend  (pend_q),
        .svc   (svc_q),
        .win_o (win),
        .top_o (top)
    );

    always_comb begin
        pend_n = pend_q;
        svc_n  = svc_q;
        if (core_done && top.valid) svc_n[top.idx] = 1'b0;
        if (core_ack && win.valid) begin
            pend_n[win.idx] = 1'b0;
            svc_n[win.idx]  = 1'b1;
        end
        pend_n = pend_n | pend_set;
    end

    always_ff @(posedge clk) begin
        if (clr_all) begin
            pend_q <= '0;
            svc_q  <= '0;
        end else begin
            pend_q <= pend_n;
            svc_q  <= svc_n;
        end
    end

    assign vec_valid     = win.valid;
    assign vec_level     = idx_to_level(win.idx);
    assign stall         = |((pend_q | svc_q) & HARD_MASK);
    assign outstanding_o = pend_q | svc_q;

    p_valid_hold_r6: assert property (@(posedge clk) disable iff (clr_all)
        vec_valid && !core_ack |=> vec_valid);

    p_retire_one_r8: assert property (@(posedge clk) disable iff (clr_all)
        core_done && !core_ack && ($countones(svc_q) > 0)
        |=> $countones(svc_q) == $past($countones(svc_q)) - 1);

    p_done_idle_r12: assert property (@(posedge clk) disable iff (clr_all)
        core_done && (svc_q == '0) && (pend_q == '0) && (pend_set == '0) |=> !vec_valid);

endmodule

// File: rtl/trap_conflict.sv
module trap_conflict
    import trap_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      por,
    input  trap_vec_t rise,
    input  trap_vec_t outstanding,
    input  logic      conflict_clr,
    output logic      reset_req,
    output logic      sticky
);

    trap_vec_t hit;
    logic      conflict;
    logic      reset_req_q;
    logic      sticky_q;

    generate
        for (genvar i = 0; i < NUM_TRAPS; i++) begin : g_hit
            if (i >= SOFT_TRAPS) begin : g_hard
                assign hit[i] = rise[i] & (|(outstanding & above_mask(IDX_W'(i))));
            end else begin : g_soft
                assign hit[i] = 1'b0;
            end
        end
    endgenerate

    assign conflict = (|hit) & ~rst;

    always_ff @(posedge clk) begin
        if (rst | por)     reset_req_q <= 1'b0;
        else if (conflict) reset_req_q <= 1'b1;
    end

    // Only a power-on reset or the software clear removes the status.
    always_ff @(posedge clk) begin
        if (por)               sticky_q <= 1'b0;
        else if (conflict)     sticky_q <= 1'b1;
        else if (conflict_clr) sticky_q <= 1'b0;
    end

    assign reset_req = reset_req_q;
    assign sticky    = sticky_q;

    p_conflict_sets_r9: assert property (@(posedge clk) disable iff (rst || por)
        conflict |=> reset_req_q && sticky_q);

    p_reset_req_hold_r9: assert property (@(posedge clk) disable iff (rst || por)
        reset_req_q |=> reset_req_q);

    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (por)
        sticky_q && !conflict_clr |=> sticky_q);

endmodule

// File: rtl/trap_arb_ctrl.sv
module trap_arb_ctrl
    import trap_arb_pkg::*;
#(
    parameter int SOFT_DELAY = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por,
    input  logic [NUM_TRAPS-1:0] trap_req,
    input  logic [NUM_TRAPS-1:0] flag_clr,
    input  logic                 core_ack,
    input  logic                 core_done,
    input  logic                 conflict_clr,
    output logic                 vec_valid,
    output logic [LVL_W-1:0]     vec_level,
    output logic                 stall,
    output logic                 reset_req,
    output logic                 conflict_sticky,
    output logic [NUM_TRAPS-1:0] trap_flags
);

    trap_vec_t rise;
    trap_vec_t pend_set;
    trap_vec_t outstanding;

    trap_capture #(.SOFT_DELAY(SOFT_DELAY)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .por        (por),
        .trap_req   (trap_req),
        .flag_clr   (flag_clr),
        .rise_o     (rise),
        .pend_set_o (pend_set),
        .flags_o    (trap_flags)
    );

    trap_tracker u_tracker (
        .clk           (clk),
        .clr_all       (rst | por),
        .pend_set      (pend_set),
        .core_ack      (core_ack),
        .core_done     (core_done),
        .vec_valid     (vec_valid),
        .vec_level     (vec_level),
        .stall         (stall),
        .outstanding_o (outstanding)
    );

    trap_conflict u_conflict (
        .clk          (clk),
        .rst          (rst),
        .por          (por),
        .rise         (rise),
        .outstanding  (outstanding),
        .conflict_clr (conflict_clr),
        .reset_req    (reset_req),
        .sticky       (conflict_sticky)
    );

endmodule

// File: tb/trap_arb_ctrl_tb.sv
module trap_arb_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por = 1'b1;
    logic [7:0] trap_req = '0;
    logic [7:0] flag_clr = '0;
    logic       core_ack = 1'b0;
    logic       core_done = 1'b0;
    logic       conflict_clr = 1'b0;
    logic       vec_valid;
    logic [3:0] vec_level;
    logic       stall;
    logic       reset_req;
    logic       conflict_sticky;
    logic [7:0] trap_flags;

    int n_chk  = 0;
    int n_fail = 0;
    bit reported = 0;
    logic [7:0] m, rem;

    // {expected first winner level, request mask}
    localparam logic [11:0] VEC_TAB [9] = '{
        {4'd8,  8'h01}, {4'd11, 8'h08}, {4'd12, 8'h10},
        {4'd14, 8'h40}, {4'd15, 8'h80}, {4'd10, 8'h05},
        {4'd13, 8'h30}, {4'd15, 8'h89}, {4'd13, 8'h24}
    };

    always #4 clk = ~clk;

    trap_arb_ctrl u_dut (
        .clk             (clk),
        .rst             (rst),
        .por             (por),
        .trap_req        (trap_req),
        .flag_clr        (flag_clr),
        .core_ack        (core_ack),
        .core_done       (core_done),
        .conflict_clr    (conflict_clr),
        .vec_valid       (vec_valid),
        .vec_level       (vec_level),
        .stall           (stall),
        .reset_req       (reset_req),
        .conflict_sticky (conflict_sticky),
        .trap_flags      (trap_flags)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int hi_bit(input logic [7:0] v);
        int r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic pulse_req(input logic [7:0] v);
        trap_req = v;
        tick();
        trap_req = '0;
    endtask

    task automatic do_ack();
        core_ack = 1'b1;
        tick();
        core_ack = 1'b0;
    endtask

    task automatic do_done();
        core_done = 1'b1;
        tick();
        core_done = 1'b0;
    endtask

    task automatic apply_rst();
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        por = 1'b0;
        // R1: reset state
        chk("R1", "vec_valid", int'(vec_valid), 0);
        chk("R1", "stall", int'(stall), 0);
        chk("R1", "reset_req", int'(reset_req), 0);
        chk("R1", "sticky", int'(conflict_sticky), 0);
        chk("R1", "flags", int'(trap_flags), 0);

        // R12: retire with nothing in service
        do_done();
        chk("R12", "vec_valid", int'(vec_valid), 0);
        chk("R12", "stall", int'(stall), 0);

        // Table walk: R2, R3, R4, R5, R6
        for (int t = 0; t < 9; t++) begin
            m = VEC_TAB[t][7:0];
            pulse_req(m);
            if (|m[7:4]) begin
                chk("R3", "hard valid after one edge", int'(vec_valid), 1);
                chk("R2", "hard level", int'(vec_level), 8 + hi_bit(m & 8'hF0));
            end else begin
                chk("R4", "soft not yet valid", int'(vec_valid), 0);
            end
            chk("R3", "stall on arrival", int'(stall), int'(|m[7:4]));
            tick();
            chk("R4", "valid after two edges", int'(vec_valid), 1);
            chk("R5", "top winner", int'(vec_level), int'(VEC_TAB[t][11:8]));
            rem = m;
            for (int b = 7; b >= 0; b--) begin
                if (rem[b]) begin
                    chk("R5", "descending order", int'(vec_level), 8 + b);
                    chk("R3", "stall while hard outstanding", int'(stall), int'(|rem[7:4]));
                    do_ack();
                    chk("R6", "valid drops after ack", int'(vec_valid), 0);
                    chk("R3", "stall in service", int'(stall), int'(|rem[7:4]));
                    rem[b] = 1'b0;
                    do_done();
                end
            end
            chk("R5", "idle valid", int'(vec_valid), 0);
            chk("R4", "idle stall", int'(stall), 0);
        end
        chk("R10", "no conflict on simultaneous", int'(reset_req), 0);

        // R7/R8: preemption and suspension
        pulse_req(8'h02);
        tick();
        chk("R6", "level 9 presented", int'(vec_level), 9);
        tick();
        chk("R6", "valid held without ack", int'(vec_valid), 1);
        do_ack();
        pulse_req(8'h10);
        chk("R7", "preempt valid", int'(vec_valid), 1);
        chk("R7", "preempt level", int'(vec_level), 12);
        chk("R10", "higher arrival no conflict", int'(reset_req), 0);
        do_ack();
        pulse_req(8'h01);
        tick();
        chk("R7", "lower pending hidden", int'(vec_valid), 0);
        chk("R10", "soft arrival no conflict", int'(reset_req), 0);
        do_done();
        chk("R8", "suspended trap still blocks", int'(vec_valid), 0);
        chk("R8", "stall released", int'(stall), 0);
        do_done();
        chk("R8", "lower revealed after resume", int'(vec_valid), 1);
        chk("R8", "lower level", int'(vec_level), 8);
        do_ack();
        do_done();
        chk("R8", "idle", int'(vec_valid), 0);

        // R9/R10: hard conflict
        pulse_req(8'h40);
        chk("R9", "level 14 pending", int'(vec_level), 14);
        pulse_req(8'h10);
        chk("R9", "reset_req on conflict", int'(reset_req), 1);
        chk("R9", "sticky on conflict", int'(conflict_sticky), 1);
        tick();
        chk("R9", "reset_req held", int'(reset_req), 1);
        apply_rst();
        chk("R1", "reset_req cleared", int'(reset_req), 0);
        chk("R1", "valid cleared", int'(vec_valid), 0);
        chk("R10", "sticky survives rst", int'(conflict_sticky), 1);
        conflict_clr = 1'b1;
        tick();
        conflict_clr = 1'b0;
        chk("R10", "sticky cleared by write", int'(conflict_sticky), 0);
        pulse_req(8'h80);
        pulse_req(8'h20);
        chk("R9", "second conflict", int'(conflict_sticky), 1);
        por = 1'b1;
        tick();
        por = 1'b0;
        chk("R1", "por clears sticky", int'(conflict_sticky), 0);
        chk("R1", "por clears reset_req", int'(reset_req), 0);

        // R11: flag clearing
        trap_req = 8'h68;
        tick();
        chk("R11", "flags set", int'(trap_flags), 'h68);
        flag_clr = 8'h68;
        tick();
        flag_clr = '0;
        chk("R11", "held flags kept", int'(trap_flags), 'h48);
        trap_req = '0;
        flag_clr = 8'h48;
        tick();
        flag_clr = '0;
        chk("R11", "flags cleared once released", int'(trap_flags), 0);
        apply_rst();
        chk("R1", "clean after rst", int'(stall), 0);

        report();
    end

endmodule